// File: doc/BRIEF.md
# APB Sample Capture FIFO

This peripheral collects a burst of converter samples into an on-chip first-in first-out buffer and hands them to a processor over an APB slave port. Sampling runs only while software has set the capture-enable bit. An interrupt line rises once the buffer holds its full complement of words (1024 by default). The processor then drains the buffer by reading one data register over and over. Each read removes exactly one entry and returns it. A word is never skipped, repeated or replaced by zeros.

The buffer's output stage is chosen at elaboration. In first-word-fallthrough mode, the oldest word sits on the output as soon as the buffer stops being empty. It stays there until it is popped, so an APB read returns it with no wait state. In conventional mode, the pop and the memory read happen in the first access cycle. The slave inserts one wait state and returns the word on the following cycle. In this mode, a hold option decides whether the popped word stays on the buffer output after that cycle. A control-register write re-arms the capture: it empties the buffer and clears the interrupt and the overflow flag.

Top module: `smpl_capture_apb`

## Requirements
- R1: After reset the buffer is empty, the fill count is 0, `cap_irq` is low, the overflow flag is clear and capture is disabled (CTRL reads 0).
- R2: A sample on `smp_valid` is stored only while CTRL bit 0 is 1. Otherwise it is ignored and the fill count does not change.
- R3: `cap_irq` goes high when the fill count reaches the depth (2^ADDR_W). It stays high, even while words are read out, until the next CTRL write.
- R4: A sample that arrives while the buffer is full is dropped, the contents are unchanged, and STATUS bit 2 (overflow) is set and stays set until the next CTRL write.
- R5: With FWFT=1, `fifo_q` shows the oldest stored word from the cycle the buffer becomes non-empty. It stays stable until that word is popped. A DATA read returns it with PREADY high in the first access cycle.
- R6: With FWFT=0, a DATA read of a non-empty buffer has exactly one wait state (PREADY low in the first access cycle, high in the second) and returns the oldest word.
- R7: With FWFT=0 and RD_HOLD=1, `fifo_q` keeps the last popped word until the next pop or CTRL write. With RD_HOLD=0, the popped word appears on `fifo_q` only in the cycle after the pop, and `fifo_q` is 0 at all other times.
- R8: A DATA read while the buffer is empty returns 0 with no wait state and does not move the read position. The next stored word is the next one returned.
- R9: A write to CTRL (offset 0x08) loads capture enable from PWDATA bit 0. In the same cycle it empties the buffer and clears overflow and `cap_irq`.
- R10: STATUS (offset 0x04) holds: bit 0 empty, bit 1 full, bit 2 overflow, bit 3 interrupt, and the fill count in bits starting at 16 (ADDR_W+1 bits wide). DATA (offset 0x00) is zero-extended. Only PADDR[3:2] is decoded.
- R11: Across any mix of stores and reads, words leave in the order they were stored, with none lost or duplicated.
- R12: A store and a pop in the same cycle both take effect, and the fill count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Sample strobe from the converter side |
| smp_data | input | DATA_W | Sample word |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | PADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, low during the conventional-mode wait state |
| cap_irq | output | 1 | Buffer-full interrupt, sticky |
| fifo_q | output | DATA_W | Buffer output word, timing set by FWFT and RD_HOLD |

## Verification
The bus checks assume an orderly APB master:
- PENABLE is raised only in the cycle after a setup phase with PSEL.
- The address and direction do not change until PREADY is seen.
- A transfer is not abandoned during the conventional-mode wait state.

The pointer checks assume that the sample strobe and bus reads may coincide, but that nothing is driven during reset. The bench drives the bus only through its read and write tasks, which follow exactly that phase order. Samples change only on the falling clock edge, and they overlap a bus access only in the one directed same-cycle case.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;
    localparam int APB_DW = 32;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_STAT = 2'd1,
        REG_CTRL = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    localparam int ST_EMPTY   = 0;
    localparam int ST_FULL    = 1;
    localparam int ST_OVF     = 2;
    localparam int ST_IRQ     = 3;
    localparam int ST_CNT_LSB = 16;
endpackage

// File: rtl/cap_store.sv
`timescale 1ns/1ps
module cap_store #(
    parameter int DW = 16,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // asynchronous read of the head entry
    assign rdata = mem_q[raddr];
endmodule

// File: rtl/cap_ptrs.sv
`timescale 1ns/1ps
module cap_ptrs #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_req,
    input  logic          pop_req,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   cnt,
    output logic          empty,
    output logic          full,
    output logic          ovf,
    output logic          irq,
    output logic          pop_ok
);
    localparam logic [AW:0]   FULL_CNT = {1'b1, {AW{1'b0}}};
    localparam logic [AW:0]   CNT_ONE  = {{AW{1'b0}}, 1'b1};
    localparam logic [AW-1:0] PTR_ONE  = {{(AW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [AW:0]   cnt;
        logic          ovf;
        logic          irq;
    } ptr_st_t;

    ptr_st_t s_d, s_q;
    logic    do_wr, do_rd;

    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == FULL_CNT);
    assign do_wr = wr_req & ~full;
    assign do_rd = pop_req & ~empty;

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d = '0;
        end else begin
            if (do_wr) s_d.wptr = s_q.wptr + PTR_ONE;
            if (do_rd) s_d.rptr = s_q.rptr + PTR_ONE;
            case ({do_wr, do_rd})
                2'b10:   s_d.cnt = s_q.cnt + CNT_ONE;
                2'b01:   s_d.cnt = s_q.cnt - CNT_ONE;
                default: s_d.cnt = s_q.cnt;
            endcase
            if (wr_req && full)          s_d.ovf = 1'b1;
            if (s_d.cnt == FULL_CNT)     s_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign we     = do_wr & ~flush;
    assign pop_ok = do_rd & ~flush;
    assign waddr  = s_q.wptr;
    assign raddr  = s_q.rptr;
    assign cnt    = s_q.cnt;
    assign ovf    = s_q.ovf;
    assign irq    = s_q.irq;

    // R2: with no store and no pop the fill level holds
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_req && !pop_req && !flush) |=> (cnt == $past(cnt)));
    // R3: interrupt is sticky until flush, and present whenever full
    a_r3_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !flush) |=> irq);
    a_r3_full_irq: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> irq);
    // R4: a store while full is dropped and flags overflow
    a_r4_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_req && !pop_req && !flush) |=> (ovf && full && waddr == $past(waddr)));
    // R8: a pop request on an empty buffer leaves the read position
    a_r8_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !flush) |=> (raddr == $past(raddr)));
    // R9: flush empties the buffer and clears flags
    a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && !irq && !ovf));
    // R12: simultaneous store and pop keep the level
    a_r12_both: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && pop_req && !full && !empty && !flush) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/cap_rdport.sv
`timescale 1ns/1ps
module cap_rdport #(
    parameter int DW      = 16,
    parameter bit FWFT    = 1'b1,
    parameter bit RD_HOLD = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          pop_ok,
    input  logic          empty,
    input  logic [DW-1:0] head,
    output logic [DW-1:0] q
);
    generate
        if (FWFT) begin : g_fall
            logic unused_fall;
            assign unused_fall = ^{flush, pop_ok};
            assign q = empty ? '0 : head;

            // R5: head stays put until popped
            a_r5_head_stable: assert property (@(posedge clk) disable iff (!rst_n)
                (!empty && !pop_ok && !flush) |=> $stable(q));
        end else begin : g_reg
            logic [DW-1:0] dout_d, dout_q;
            logic          unused_reg;
            assign unused_reg = empty;

            always_comb begin
                dout_d = RD_HOLD ? dout_q : '0;
                if (pop_ok) dout_d = head;
                if (flush)  dout_d = '0;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) dout_q <= '0;
                else        dout_q <= dout_d;
            end

            assign q = dout_q;

            if (RD_HOLD) begin : g_hold
                // R7: popped word held until next pop or flush
                a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
                    (!pop_ok && !flush) |=> $stable(q));
            end else begin : g_pulse
                // R7: without hold the word lasts a single cycle
                a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
                    !pop_ok |=> (q == '0));
            end
        end
    endgenerate
endmodule

// File: rtl/cap_apb.sv
`timescale 1ns/1ps
module cap_apb
    import cap_pkg::*;
#(
    parameter int DW   = 16,
    parameter int AW   = 10,
    parameter int PAW  = 8,
    parameter bit FWFT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [PAW-1:0]    paddr,
    input  logic [APB_DW-1:0] pwdata,
    output logic [APB_DW-1:0] prdata,
    output logic              pready,
    input  logic [DW-1:0]     q,
    input  logic              empty,
    input  logic              full,
    input  logic              ovf,
    input  logic              irq,
    input  logic [AW:0]       cnt,
    output logic              pop,
    output logic              flush,
    output logic              cap_en
);
    typedef struct packed {
        logic pend;
        logic cap_en;
    } apb_st_t;

    apb_st_t  s_d, s_q;
    reg_sel_e sel;
    logic     acc;
    logic     unused_bits;

    assign unused_bits = ^{pwdata[APB_DW-1:1], paddr[PAW-1:4], paddr[1:0]};
    assign acc = psel & penable;

    always_comb begin
        case (paddr[3:2])
            2'd0:    sel = REG_DATA;
            2'd1:    sel = REG_STAT;
            2'd2:    sel = REG_CTRL;
            default: sel = REG_NONE;
        endcase
    end

    always_comb begin
        s_d    = s_q;
        pop    = 1'b0;
        flush  = 1'b0;
        pready = 1'b1;
        prdata = '0;
        if (acc && pwrite && sel == REG_CTRL) begin
            s_d.cap_en = pwdata[0];
            flush      = 1'b1;
        end
        if (acc && !pwrite) begin
            case (sel)
                REG_DATA: begin
                    if (FWFT) begin
                        prdata[DW-1:0] = q;
                        pop            = ~empty;
                    end else if (s_q.pend) begin
                        prdata[DW-1:0] = q;
                        s_d.pend       = 1'b0;
                    end else if (!empty) begin
                        pop      = 1'b1;
                        pready   = 1'b0;
                        s_d.pend = 1'b1;
                    end
                end
                REG_STAT: begin
                    prdata[ST_EMPTY]             = empty;
                    prdata[ST_FULL]              = full;
                    prdata[ST_OVF]               = ovf;
                    prdata[ST_IRQ]               = irq;
                    prdata[ST_CNT_LSB +: AW + 1] = cnt;
                end
                REG_CTRL: prdata[0] = s_q.cap_en;
                default:  prdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cap_en = s_q.cap_en;

    // R6: the wait state lasts exactly one cycle
    a_r6_one_wait: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pend |-> pready);
    a_r6_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pend |=> !s_q.pend);
    // R8: never request a pop of an empty buffer
    a_r8_no_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/smpl_capture_apb.sv
`timescale 1ns/1ps
module smpl_capture_apb
    import cap_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 10,
    parameter bit FWFT    = 1'b1,
    parameter bit RD_HOLD = 1'b1,
    parameter int PADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_valid,
    input  logic [DATA_W-1:0]  smp_data,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [PADDR_W-1:0] paddr,
    input  logic [31:0]        pwdata,
    output logic [31:0]        prdata,
    output logic               pready,
    output logic               cap_irq,
    output logic [DATA_W-1:0]  fifo_q
);
    logic              cap_en, pop, pop_ok, flush, we;
    logic              empty, full, ovf;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [ADDR_W:0]   cnt;
    logic [DATA_W-1:0] head;

    cap_ptrs #(.AW(ADDR_W)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .wr_req(smp_valid & cap_en), .pop_req(pop),
        .we(we), .waddr(waddr), .raddr(raddr), .cnt(cnt),
        .empty(empty), .full(full), .ovf(ovf), .irq(cap_irq), .pop_ok(pop_ok)
    );

    cap_store #(.DW(DATA_W), .AW(ADDR_W)) u_store (
        .clk(clk), .we(we), .waddr(waddr), .wdata(smp_data),
        .raddr(raddr), .rdata(head)
    );

    cap_rdport #(.DW(DATA_W), .FWFT(FWFT), .RD_HOLD(RD_HOLD)) u_rd (
        .clk(clk), .rst_n(rst_n), .flush(flush), .pop_ok(pop_ok),
        .empty(empty), .head(head), .q(fifo_q)
    );

    cap_apb #(.DW(DATA_W), .AW(ADDR_W), .PAW(PADDR_W), .FWFT(FWFT)) u_apb (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .q(fifo_q), .empty(empty), .full(full), .ovf(ovf), .irq(cap_irq), .cnt(cnt),
        .pop(pop), .flush(flush), .cap_en(cap_en)
    );

    // R2: disabled capture never stores
    a_r2_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && !pop && !flush) |=> $stable(cnt));
endmodule

// File: tb/sim_smpl_capture_apb.sv
`timescale 1ns/1ps
module sim_smpl_capture_apb;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic [2:0]    psel = '0;
    logic          penable = 1'b0;
    logic          pwrite = 1'b0;
    logic [7:0]    paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata [3];
    logic          pready [3];
    logic          irq [3];
    logic [DW-1:0] fq [3];

    always #10 clk = ~clk;

    smpl_capture_apb #(.DATA_W(DW), .ADDR_W(10), .FWFT(1'b1), .RD_HOLD(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .psel(psel[0]), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata[0]), .pready(pready[0]), .cap_irq(irq[0]), .fifo_q(fq[0]));
    smpl_capture_apb #(.DATA_W(DW), .ADDR_W(4), .FWFT(1'b0), .RD_HOLD(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .psel(psel[1]), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata[1]), .pready(pready[1]), .cap_irq(irq[1]), .fifo_q(fq[1]));
    smpl_capture_apb #(.DATA_W(DW), .ADDR_W(4), .FWFT(1'b0), .RD_HOLD(1'b0)) u2 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .psel(psel[2]), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata[2]), .pready(pready[2]), .cap_irq(irq[2]), .fifo_q(fq[2]));

    // reference model
    logic [DW-1:0] mq [3][$];
    int            depth [3] = '{1024, 16, 16};
    bit            m_en  [3] = '{0, 0, 0};
    bit            m_ovf [3] = '{0, 0, 0};
    bit            m_irq [3] = '{0, 0, 0};
    logic [DW-1:0] last_q [3] = '{0, 0, 0};
    int            n_chk = 0;
    int            n_bad = 0;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: got %0h expected %0h", req, $time, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status(int i);
        logic [31:0] s;
        s    = '0;
        s[0] = (mq[i].size() == 0);
        s[1] = (mq[i].size() == depth[i]);
        s[2] = m_ovf[i];
        s[3] = m_irq[i];
        s    = s | (32'(mq[i].size()) << 16);
        return s;
    endfunction

    function automatic void m_push(logic [DW-1:0] v);
        for (int i = 0; i < 3; i++) begin
            if (m_en[i]) begin
                if (mq[i].size() < depth[i]) begin
                    mq[i].push_back(v);
                    if (mq[i].size() == depth[i]) m_irq[i] = 1'b1;
                end else begin
                    m_ovf[i] = 1'b1;
                end
            end
        end
    endfunction

    task automatic apb_rd(int i, logic [7:0] a, output logic [31:0] d, output int waits);
        @(negedge clk); psel[i] = 1'b1; paddr = a; pwrite = 1'b0; penable = 1'b0;
        @(negedge clk); penable = 1'b1; waits = 0;
        #1;
        while (!pready[i]) begin
            waits++;
            @(negedge clk); #1;
        end
        d = prdata[i];
        @(negedge clk); psel[i] = 1'b0; penable = 1'b0;
    endtask

    task automatic apb_wr(int i, logic [7:0] a, logic [31:0] v);
        @(negedge clk); psel[i] = 1'b1; paddr = a; pwrite = 1'b1; pwdata = v; penable = 1'b0;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel[i] = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic set_ctrl(int i, bit en);
        apb_wr(i, 8'h08, {31'b0, en});
        m_en[i] = en; mq[i].delete(); m_ovf[i] = 1'b0; m_irq[i] = 1'b0; last_q[i] = '0;
    endtask

    task automatic push_n(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_data  = DW'($urandom());
            m_push(smp_data);
        end
        @(negedge clk); smp_valid = 1'b0;
    endtask

    task automatic st_chk(int i, string req);
        logic [31:0] d; int w;
        apb_rd(i, 8'h04, d, w);
        chk(req, d, exp_status(i));
    endtask

    task automatic rd_data(int i, string req);
        logic [31:0] d, exp; int w, expw;
        if (mq[i].size() > 0) begin
            exp = 32'(mq[i].pop_front());
            expw = (i == 0) ? 0 : 1;
            last_q[i] = exp[DW-1:0];
        end else begin
            exp = '0; expw = 0; req = "R8";
        end
        apb_rd(i, 8'h00, d, w);
        chk(req, d, exp);
        chk((i == 0) ? "R5" : "R6", 32'(w), 32'(expw));
    endtask

    task automatic same_cycle_test();
        logic [31:0] d, exp; int w; logic [DW-1:0] v;
        v = DW'($urandom());
        exp = 32'(mq[0][0]);
        fork
            apb_rd(0, 8'h00, d, w);
            begin
                @(negedge clk); @(negedge clk);
                smp_valid = 1'b1; smp_data = v;
                @(negedge clk); smp_valid = 1'b0;
            end
        join
        void'(mq[0].pop_front());
        m_push(v);
        chk("R12", d, exp);
        st_chk(0, "R12");
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #4000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        logic [31:0] d; int w;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 3; i++) begin
            st_chk(i, "R1");
            chk("R1", 32'(irq[i]), 32'd0);
            apb_rd(i, 8'h08, d, w);
            chk("R1", d, 32'd0);
        end

        // R2 samples ignored while disabled
        push_n(5);
        for (int i = 0; i < 3; i++) st_chk(i, "R2");

        // R3 / R10 fill u0
        set_ctrl(0, 1'b1);
        apb_rd(0, 8'h08, d, w);
        chk("R9", d, 32'd1);
        push_n(1023);
        chk("R3", 32'(irq[0]), 32'd0);
        push_n(1);
        chk("R3", 32'(irq[0]), 32'd1);
        st_chk(0, "R10");
        // R10 aliasing: upper address bits ignored
        apb_rd(0, 8'h44, d, w);
        chk("R10", d, exp_status(0));

        // R4 overflow
        push_n(2);
        st_chk(0, "R4");

        // R5 head stable while idle
        chk("R5", 32'(fq[0]), 32'(mq[0][0]));
        repeat (7) @(negedge clk);
        chk("R5", 32'(fq[0]), 32'(mq[0][0]));

        // R11 drain with gaps, R12 midway
        for (int k = 0; k < 500; k++) begin
            rd_data(0, "R11");
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end
        chk("R3", 32'(irq[0]), 32'd1);
        same_cycle_test();
        while (mq[0].size() > 0) rd_data(0, "R11");

        // R8 empty read, then first word not lost
        rd_data(0, "R8");
        st_chk(0, "R8");
        push_n(1);
        chk("R5", 32'(fq[0]), 32'(mq[0][0]));
        rd_data(0, "R8");

        // R9 ctrl write clears
        push_n(3);
        set_ctrl(0, 1'b0);
        st_chk(0, "R9");
        chk("R9", 32'(irq[0]), 32'd0);

        // conventional modes, random mix
        set_ctrl(1, 1'b1);
        set_ctrl(2, 1'b1);
        for (int k = 0; k < 400; k++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 4) begin
                push_n($urandom_range(1, 6));
            end else if (r < 7) begin
                rd_data(1, "R11");
                chk("R7", 32'(fq[1]), 32'(last_q[1]));
                repeat (3) @(negedge clk);
                chk("R7", 32'(fq[1]), 32'(last_q[1]));
            end else begin
                rd_data(2, "R11");
                chk("R7", 32'(fq[2]), 32'd0);
            end
            if (k % 50 == 0) begin
                st_chk(1, "R10");
                st_chk(2, "R4");
                chk("R3", 32'(irq[1]), 32'(m_irq[1]));
            end
        end
        while (mq[1].size() > 0) rd_data(1, "R6");
        while (mq[2].size() > 0) rd_data(2, "R6");
        rd_data(1, "R8");
        st_chk(1, "R8");
        st_chk(2, "R10");

        report();
    end
endmodule